// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the byte-load path of a flash-style sector programmer and its program engine. It watches every byte-load event (address plus data byte), recognises the command sequences that switch software write protection on and off, and keeps a protection flag that only the disable command or a power-on reset clears. For every load window it tells the program engine two things. Bytes that are real sector data come out on the write outputs. When the window closes, a program-start pulse comes out together with a qualifier. The qualifier says whether the cycle commits data or only runs the program timer. A timer-only cycle keeps status polling working.

A load window opens on any byte load and closes after `WINDOW_CYCLES` clock cycles without a further load. While protection is on, a window must open with the three-write unlock sequence for its data to be written. Loads in a protected window without that prefix are swallowed, but the window still ends with a program-start pulse that has the qualifier low. The unlock sequence also turns protection on when it is off. A six-write sequence turns protection off. Command recognition compares only the low `CMP_W` address bits.

Top module: `wp_guard`

## Requirements
- R1: After synchronous reset `prot_on`, `wr_en`, `prog_go`, `prog_ok`, `en_done` and `dis_done` are all 0. Protection is off out of reset.
- R2: While protection is off, each data load appears one cycle later as `wr_en`=1 with the same address and byte. `WINDOW_CYCLES`+1 cycles after the last load of a window, `prog_go` pulses for one cycle with `prog_ok`=1.
- R3: Three loads at the window start, low-15-bit address/data 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, form the unlock sequence. It sets `prot_on` and pulses `en_done` one cycle after the third load. These loads are never forwarded as writes. Address bits above `CMP_W` do not affect the match.
- R4: While protected, data loads in a window that did not start with the unlock sequence produce no `wr_en`. The window still ends with a `prog_go` pulse that has `prog_ok`=0.
- R5: While protected, data loads that follow the unlock sequence in the same window are written. The window ends with `prog_ok`=1.
- R6: The six loads 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20 at a window start clear `prot_on` and pulse `dis_done`. None of them is forwarded.
- R7: A load that breaks a partly matched sequence returns the matcher to idle and is handled as a data load under the current protection state.
- R8: If the window closes partway through a sequence, the matcher returns to idle. A window that held no data load produces no `prog_go`.
- R9: `prot_on` changes only on an unlock that completes while protection is off, or on a completed disable. Blocked cycles, aborted sequences and window closes leave it unchanged.
- R10: Sequences are recognised only before the first data load of a window. After that, command-shaped loads are ordinary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| ld_valid | input | 1 | One-cycle byte-load event |
| ld_addr | input | ADDR_W | Address of the byte load |
| ld_data | input | 8 | Data byte of the byte load |
| wr_en | output | 1 | Forwarded data byte may be stored |
| wr_addr | output | ADDR_W | Address of the forwarded byte |
| wr_data | output | 8 | Forwarded data byte |
| prog_go | output | 1 | Pulse: start the program timer for the closed window |
| prog_ok | output | 1 | Qualifier with `prog_go`: 1 commits data, 0 runs the timer only |
| prot_on | output | 1 | Software protection flag |
| en_done | output | 1 | Pulse: unlock/enable sequence completed |
| dis_done | output | 1 | Pulse: disable sequence completed |

## Verification
On every cycle the assertions check four things. A forwarded write carries the previous cycle's load. Writes and command pulses never coincide. `prot_on` moves only together with a command pulse, and `prog_go` is a single pulse that follows a quiet load input. Whether a window is authorised depends on what came before it: the protection state at that time, the position of the unlock prefix, timeouts partway through a sequence and breaking loads. Only the bench's directed scenarios show these cases, by checking the write and program-start outputs against expected values.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int BYTE_W = 8;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W = $clog2(SEQ_LEN);

  localparam logic [15:0] ADDR_HI_CMD = 16'h5555;
  localparam logic [15:0] ADDR_LO_CMD = 16'h2AAA;

  typedef enum logic [1:0] {
    SEQ_NONE = 2'd0,
    SEQ_ADV  = 2'd1,
    SEQ_EN   = 2'd2,
    SEQ_DIS  = 2'd3
  } seq_hit_e;

  // Judge one load against the sequence position it would extend.
  function automatic seq_hit_e seq_eval(input logic [STEP_W-1:0] step,
                                        input logic [15:0] a,
                                        input logic [BYTE_W-1:0] d);
    seq_hit_e r;
    r = SEQ_NONE;
    case (step)
      3'd0, 3'd3: if (a == ADDR_HI_CMD && d == 8'hAA) r = SEQ_ADV;
      3'd1, 3'd4: if (a == ADDR_LO_CMD && d == 8'h55) r = SEQ_ADV;
      3'd2: begin
        if (a == ADDR_HI_CMD && d == 8'hA0) r = SEQ_EN;
        else if (a == ADDR_HI_CMD && d == 8'h80) r = SEQ_ADV;
      end
      3'd5: if (a == ADDR_HI_CMD && d == 8'h20) r = SEQ_DIS;
      default: r = SEQ_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wp_load_window.sv
module wp_load_window #(
  parameter int WINDOW_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_valid,
  output logic close
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      close  <= 1'b0;
    end else begin
      close <= 1'b0;
      if (ld_valid) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
      end else if (open_q) begin
        if (cnt_q == LAST) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
          close  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              eligible,
  input  logic              ld_valid,
  input  logic [CMP_W-1:0]  ld_addr_lo,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              is_cmd,
  output logic              en_hit,
  output logic              dis_hit
);
  logic [STEP_W-1:0] step_q, step_base, step_nx;
  logic [15:0]       a16;
  seq_hit_e          hit;

  always_comb begin
    a16       = 16'(ld_addr_lo);
    step_base = clear ? '0 : step_q;
    hit       = seq_eval(step_base, a16, ld_data);
    is_cmd    = 1'b0;
    en_hit    = 1'b0;
    dis_hit   = 1'b0;
    step_nx   = step_base;
    if (ld_valid) begin
      if (eligible && hit != SEQ_NONE) begin
        is_cmd  = 1'b1;
        en_hit  = (hit == SEQ_EN);
        dis_hit = (hit == SEQ_DIS);
        step_nx = (hit == SEQ_ADV) ? step_base + 1'b1 : '0;
      end else begin
        step_nx = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_nx;
  end
endmodule

// File: rtl/wp_flag_cell.sv
module wp_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int CMP_W         = 15,
  parameter int WINDOW_CYCLES = 37500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              prog_go,
  output logic              prog_ok,
  output logic              prot_on,
  output logic              en_done,
  output logic              dis_done
);
  logic close;
  logic has_data_q, unlocked_q, cycle_ok_q;
  logic has_data_b, unlocked_b;
  logic eligible, is_cmd, en_hit, dis_hit, data_ld, auth;

  wp_load_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .close(close)
  );

  // A closing window hands a clean session to a load on the same edge.
  always_comb begin
    has_data_b = close ? 1'b0 : has_data_q;
    unlocked_b = close ? 1'b0 : unlocked_q;
    eligible   = !has_data_b && !unlocked_b;
  end

  wp_seq_matcher #(.CMP_W(CMP_W)) u_match (
    .clk(clk), .rst(rst), .clear(close), .eligible(eligible),
    .ld_valid(ld_valid), .ld_addr_lo(ld_addr[CMP_W-1:0]), .ld_data(ld_data),
    .is_cmd(is_cmd), .en_hit(en_hit), .dis_hit(dis_hit)
  );

  wp_flag_cell u_flag (
    .clk(clk), .rst(rst), .set(en_hit), .clr(dis_hit), .flag(prot_on)
  );

  always_comb begin
    data_ld = ld_valid && !is_cmd;
    auth    = !prot_on || unlocked_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      has_data_q <= 1'b0;
      unlocked_q <= 1'b0;
      cycle_ok_q <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      prog_go    <= 1'b0;
      prog_ok    <= 1'b0;
      en_done    <= 1'b0;
      dis_done   <= 1'b0;
    end else begin
      prog_go    <= close && has_data_q;
      prog_ok    <= close && has_data_q && cycle_ok_q;
      has_data_q <= has_data_b || data_ld;
      unlocked_q <= unlocked_b || en_hit;
      if (data_ld && !has_data_b) cycle_ok_q <= auth;
      wr_en      <= data_ld && auth;
      if (data_ld) begin
        wr_addr <= ld_addr;
        wr_data <= ld_data;
      end
      en_done  <= en_hit;
      dis_done <= dis_hit;
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [7:0]        ld_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              prog_go,
  input logic              prog_ok,
  input logic              prot_on,
  input logic              en_done,
  input logic              dis_done
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!prot_on && !wr_en && !prog_go && !en_done && !dis_done));

  p_write_echo_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(ld_valid) && wr_addr == $past(ld_addr) && wr_data == $past(ld_data)));

  p_go_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    prog_go |-> (!$past(ld_valid, 2) && !$past(prog_go)));

  p_ok_with_go_r4: assert property (@(posedge clk) disable iff (rst)
    prog_ok |-> prog_go);

  p_en_sets_r3: assert property (@(posedge clk) disable iff (rst)
    en_done |-> prot_on);

  p_dis_clears_r6: assert property (@(posedge clk) disable iff (rst)
    dis_done |-> !prot_on);

  p_flag_moves_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_on) |-> (en_done || dis_done));

  p_cmd_not_data_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, en_done, dis_done}));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .prog_go(prog_go),
  .prog_ok(prog_ok), .prot_on(prot_on), .en_done(en_done), .dis_done(dis_done)
);

// File: tb/sim_wp_guard.sv
`timescale 1ns/1ps
module sim_wp_guard;
  localparam int AW = 18;
  localparam int W  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic          wr_en, prog_go, prog_ok, prot_on, en_done, dis_done;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wp_guard #(.ADDR_W(AW), .CMP_W(15), .WINDOW_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .prog_go(prog_go),
    .prog_ok(prog_ok), .prot_on(prot_on), .en_done(en_done), .dis_done(dis_done)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one load, then check the registered write outputs.
  task automatic do_load(input logic [AW-1:0] a, input logic [7:0] d, input bit exp_wr, input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk(wr_en == exp_wr, tag, wr_en, exp_wr);
    if (exp_wr) chk(wr_addr == a && wr_data == d, tag, {wr_addr, wr_data}, {a, d});
  endtask

  task automatic wait_close(input bit exp_ok, input string tag);
    repeat (W) @(posedge clk);
    #1 chk(prog_go == 1'b0, tag, prog_go, 0);
    @(posedge clk); #1;
    chk(prog_go == 1'b1, tag, prog_go, 1);
    chk(prog_ok == exp_ok, tag, prog_ok, exp_ok);
  endtask

  task automatic wait_quiet(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < W + 4; i++) begin
      @(posedge clk); #1;
      if (prog_go) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(!prot_on && !wr_en && !prog_go && !prog_ok && !en_done && !dis_done,
        "R1 reset state", {prot_on, wr_en, prog_go, prog_ok, en_done, dis_done}, 0);
  endtask

  task automatic t_unprot;
    do_load(18'h00100, 8'h11, 1, "R2 write a");
    do_load(18'h00107, 8'h22, 1, "R2 write b");
    do_load(18'h001FF, 8'h33, 1, "R2 write c");
    wait_close(1, "R2 close ok");
  endtask

  task automatic t_enable;
    do_load(18'h25555, 8'hAA, 0, "R3 step1 swallowed (upper addr bits set)");
    do_load(18'h02AAA, 8'h55, 0, "R3 step2 swallowed");
    do_load(18'h05555, 8'hA0, 0, "R3 step3 swallowed");
    chk(en_done && prot_on, "R3 enable pulse and flag", {en_done, prot_on}, 2'b11);
    do_load(18'h00200, 8'h44, 1, "R3 data after unlock written");
    chk(!en_done, "R3 enable pulse single", en_done, 0);
    wait_close(1, "R3 close ok");
  endtask

  task automatic t_blocked;
    do_load(18'h00300, 8'h55, 0, "R4 unprefixed load dropped");
    do_load(18'h00301, 8'h66, 0, "R4 unprefixed load dropped 2");
    wait_close(0, "R4 timer-only cycle");
    chk(prot_on, "R9 flag kept after blocked cycle", prot_on, 1);
  endtask

  task automatic t_prefixed;
    do_load(18'h05555, 8'hAA, 0, "R5 prefix1");
    do_load(18'h02AAA, 8'h55, 0, "R5 prefix2");
    do_load(18'h05555, 8'hA0, 0, "R5 prefix3");
    do_load(18'h00400, 8'h77, 1, "R5 data written");
    do_load(18'h05555, 8'hAA, 1, "R5 command-shaped data written");
    wait_close(1, "R5 close ok");
    chk(prot_on, "R5 flag stays", prot_on, 1);
  endtask

  task automatic t_mismatch;
    do_load(18'h05555, 8'hAA, 0, "R7 step1");
    do_load(18'h02AAA, 8'h55, 0, "R7 step2");
    do_load(18'h01234, 8'h33, 0, "R7 breaking load is blocked data");
    chk(!en_done, "R7 no enable", en_done, 0);
    do_load(18'h05555, 8'hA0, 0, "R7 matcher idle, step3 not accepted");
    chk(!en_done, "R7 no enable after break", en_done, 0);
    wait_close(0, "R7 close blocked");
    chk(prot_on, "R9 flag kept after break", prot_on, 1);
  endtask

  task automatic t_timeout;
    do_load(18'h05555, 8'hAA, 0, "R8 step1");
    do_load(18'h02AAA, 8'h55, 0, "R8 step2");
    wait_quiet("R8 no prog_go for command-only window");
    do_load(18'h05555, 8'hA0, 0, "R8 stale step3 is blocked data");
    chk(!en_done, "R8 no enable after timeout", en_done, 0);
    wait_close(0, "R8 close blocked");
  endtask

  task automatic t_disable;
    do_load(18'h05555, 8'hAA, 0, "R6 d1");
    do_load(18'h02AAA, 8'h55, 0, "R6 d2");
    do_load(18'h05555, 8'h80, 0, "R6 d3");
    do_load(18'h05555, 8'hAA, 0, "R6 d4");
    do_load(18'h02AAA, 8'h55, 0, "R6 d5");
    do_load(18'h05555, 8'h20, 0, "R6 d6");
    chk(dis_done && !prot_on, "R6 disable pulse and flag", {dis_done, prot_on}, 2'b10);
    wait_quiet("R6 no prog_go after disable");
    do_load(18'h00500, 8'h99, 1, "R6 write after disable");
    wait_close(1, "R6 close ok");
  endtask

  task automatic t_data_first;
    do_load(18'h00600, 8'h5A, 1, "R10 first data");
    do_load(18'h05555, 8'hAA, 1, "R10 AA is data");
    do_load(18'h02AAA, 8'h55, 1, "R10 55 is data");
    do_load(18'h05555, 8'hA0, 1, "R10 A0 is data");
    chk(!en_done && !prot_on, "R10 no enable", {en_done, prot_on}, 0);
    wait_close(1, "R10 close ok");
  endtask

  task automatic t_reset_clears;
    do_load(18'h05555, 8'hAA, 0, "R1 re-enable 1");
    do_load(18'h02AAA, 8'h55, 0, "R1 re-enable 2");
    do_load(18'h05555, 8'hA0, 0, "R1 re-enable 3");
    chk(prot_on, "R3 enabled again", prot_on, 1);
    wait_quiet("R8 unlock-only window no prog_go");
    t_reset;
    chk(!prot_on, "R1 reset clears flag", prot_on, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog run=%0d expected=done", n_run);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_unprot;
    t_enable;
    t_blocked;
    t_prefixed;
    t_mismatch;
    t_timeout;
    t_disable;
    t_data_first;
    t_reset_clears;
    repeat (4) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule